// File: doc/BRIEF.md
# Asynchronous SRAM Access Controller

This block lets a clocked system read and write a byte-wide asynchronous static RAM. The host side has a request/acknowledge port: an address, write data, a write flag and the returned read data. The memory side has an address bus, two chip selects of opposite polarity, an active-low output enable and an active-low write strobe. The bidirectional data pins are split into an output value, an input value and a drive enable.

The memory has no clock, so every timing limit becomes a count of controller clocks. These counts are fixed at elaboration from a clock-period parameter and a speed-grade switch. The fast grade needs 35 ns of access time and up to 10 ns for the outputs to float. The slow grade needs 70 ns and 25 ns. When the controller is idle it deselects the memory, so the memory stays in standby.

The host raises `host_req` with the request fields and holds them until `host_ack` pulses. It then drops `host_req` before the next clock edge.

Top module: `sram_ctl`

## Requirements
- R1: After reset and whenever no access is in progress: `mem_sel_n`=1, `mem_sel`=0, `mem_oe_n`=1, `mem_we_n`=1 and `mem_dq_oe`=0.
- R2: During a read: `mem_sel_n`=0, `mem_sel`=1, `mem_oe_n`=0, `mem_we_n`=1 and `mem_dq_oe`=0, and `mem_addr` equals the requested address.
- R3: `mem_oe_n` is low for exactly RD clocks, where RD = ceil(A/T) with A = 35000 ps (fast grade) or 70000 ps (slow grade) and T = `CLK_PS`. `mem_dq_in` is sampled on the last of these edges, before the address changes, and `host_rdata` carries that byte from the acknowledge cycle until the next read completes.
- R4: In a write, address and data are driven with `mem_dq_oe`=1, the chip is selected and `mem_we_n`=1 for exactly one clock before `mem_we_n` falls.
- R5: `mem_we_n` stays low for exactly RD clocks (the same count as R3). During that time the chip stays selected and the data stays driven.
- R6: After `mem_we_n` rises, address, data, chip select and `mem_dq_oe`=1 are held unchanged for exactly one more clock. After that the controller acknowledges.
- R7: `mem_dq_oe`=1 and `mem_oe_n`=0 never hold in the same cycle.
- R8: After `mem_oe_n` rises at the end of a read, `mem_dq_oe` stays low for at least TA+1 clocks, where TA = ceil(F/T) with F = 10000 ps (fast grade) or 25000 ps (slow grade).
- R9: Each request produces exactly one `host_ack` pulse, one clock long. A request is accepted only while the controller is idle and `host_ack` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_req | input | 1 | Request, held until acknowledged |
| host_wr | input | 1 | 1 = write, 0 = read |
| host_addr | input | ADDR_W | Word address |
| host_wdata | input | DATA_W | Write byte |
| host_ack | output | 1 | One-clock completion pulse |
| host_rdata | output | DATA_W | Last byte read |
| mem_addr | output | ADDR_W | Memory address bus |
| mem_sel_n | output | 1 | Low-true chip select |
| mem_sel | output | 1 | High-true chip select |
| mem_oe_n | output | 1 | Low-true output enable |
| mem_we_n | output | 1 | Low-true write strobe |
| mem_dq_out | output | DATA_W | Data driven toward the memory |
| mem_dq_in | input | DATA_W | Data returned by the memory |
| mem_dq_oe | output | 1 | Drive enable of the data pins |

## Verification
The bench builds the controller with ADDR_W=6, the fast grade and an 8000 ps period. That gives a 64-byte address space, RD=5 and TA=2. The small space lets every location be written and then read back. The bench then repeats read-write-read triples on every address, so the turnaround after each read is observed on every location. The bench's memory model returns a wrong byte until output enable has been low for RD-1 clocks, so a capture that comes too early is caught.

// File: rtl/sram_ctl_pkg.sv
package sram_ctl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_READ,
    ST_WSETUP,
    ST_WPULSE,
    ST_WHOLD
  } ctl_state_t;

  function automatic int ceil_div(input int num, input int den);
    return (num + den - 1) / den;
  endfunction

  function automatic int at_least_one(input int v);
    return (v < 1) ? 1 : v;
  endfunction

endpackage

// File: rtl/sram_wait_ctr.sv
module sram_wait_ctr #(
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          zero
);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)
      cnt <= '0;
    else if (load)
      cnt <= load_val;
    else if (cnt != '0)
      cnt <= cnt - 1'b1;
  end

  assign zero = (cnt == '0);

  // once drained, the count stays drained until reloaded (R3, R5, R8)
  p_ctr_hold_zero_r8: assert property (@(posedge clk) disable iff (rst)
    (zero && !load) |=> zero);

endmodule

// File: rtl/sram_dq_path.sv
module sram_dq_path #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              latch_wr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              drive_n,
  input  logic              capture,
  input  logic [DATA_W-1:0] dq_in,
  output logic [DATA_W-1:0] dq_out,
  output logic              dq_oe,
  output logic [DATA_W-1:0] rdata
);

  always_ff @(posedge clk) begin
    if (rst) begin
      dq_out <= '0;
      dq_oe  <= 1'b0;
      rdata  <= '0;
    end else begin
      if (latch_wr) dq_out <= wdata;
      dq_oe <= drive_n;
      if (capture) rdata <= dq_in;
    end
  end

  // write data does not change while it is being driven (R5, R6)
  p_data_stable_r6: assert property (@(posedge clk) disable iff (rst)
    (dq_oe && $past(dq_oe)) |-> $stable(dq_out));

endmodule

// File: rtl/sram_ctl.sv
module sram_ctl
  import sram_ctl_pkg::*;
#(
  parameter int ADDR_W     = 17,
  parameter int DATA_W     = 8,
  parameter int CLK_PS     = 8000,
  parameter int FAST_GRADE = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              host_req,
  input  logic              host_wr,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [DATA_W-1:0] host_wdata,
  output logic              host_ack,
  output logic [DATA_W-1:0] host_rdata,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_sel_n,
  output logic              mem_sel,
  output logic              mem_oe_n,
  output logic              mem_we_n,
  output logic [DATA_W-1:0] mem_dq_out,
  input  logic [DATA_W-1:0] mem_dq_in,
  output logic              mem_dq_oe
);

  localparam int ACCESS_PS = ((FAST_GRADE != 0) ? 35 : 70) * 1000;
  localparam int FLOAT_PS  = ((FAST_GRADE != 0) ? 10 : 25) * 1000;
  localparam int RD_CYC    = at_least_one(ceil_div(ACCESS_PS, CLK_PS));
  localparam int TA_CYC    = at_least_one(ceil_div(FLOAT_PS, CLK_PS));
  localparam int MAX_CYC   = (RD_CYC > TA_CYC) ? RD_CYC : TA_CYC;
  localparam int CW        = $clog2(MAX_CYC + 1);
  localparam logic [CW-1:0] PHASE_LOAD = CW'(RD_CYC - 1);
  localparam logic [CW-1:0] TURN_LOAD  = CW'(TA_CYC);

  ctl_state_t state, state_n;
  logic accept, phase_load, phase_zero, turn_load, turn_zero;
  logic capture, done, latch_wr, drive_n;

  assign accept = host_req && !host_ack && (state == ST_IDLE);

  always_comb begin
    state_n    = state;
    phase_load = 1'b0;
    turn_load  = 1'b0;
    capture    = 1'b0;
    done       = 1'b0;
    latch_wr   = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (accept && !host_wr) begin
          state_n    = ST_READ;
          phase_load = 1'b1;
        end else if (accept && turn_zero) begin
          state_n  = ST_WSETUP;
          latch_wr = 1'b1;
        end
      end
      ST_READ: begin
        if (phase_zero) begin
          capture   = 1'b1;
          done      = 1'b1;
          turn_load = 1'b1;
          state_n   = ST_IDLE;
        end
      end
      ST_WSETUP: begin
        state_n    = ST_WPULSE;
        phase_load = 1'b1;
      end
      ST_WPULSE: begin
        if (phase_zero) state_n = ST_WHOLD;
      end
      ST_WHOLD: begin
        done    = 1'b1;
        state_n = ST_IDLE;
      end
      default: state_n = ST_IDLE;
    endcase
  end

  assign drive_n = (state_n == ST_WSETUP) || (state_n == ST_WPULSE) ||
                   (state_n == ST_WHOLD);

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      host_ack  <= 1'b0;
      mem_addr  <= '0;
      mem_sel_n <= 1'b1;
      mem_sel   <= 1'b0;
      mem_oe_n  <= 1'b1;
      mem_we_n  <= 1'b1;
    end else begin
      state     <= state_n;
      host_ack  <= done;
      if (accept && (!host_wr || turn_zero)) mem_addr <= host_addr;
      mem_sel_n <= (state_n == ST_IDLE);
      mem_sel   <= (state_n != ST_IDLE);
      mem_oe_n  <= (state_n != ST_READ);
      mem_we_n  <= (state_n != ST_WPULSE);
    end
  end

  sram_wait_ctr #(.CW(CW)) u_phase (
    .clk(clk), .rst(rst), .load(phase_load), .load_val(PHASE_LOAD),
    .zero(phase_zero)
  );

  sram_wait_ctr #(.CW(CW)) u_turn (
    .clk(clk), .rst(rst), .load(turn_load), .load_val(TURN_LOAD),
    .zero(turn_zero)
  );

  sram_dq_path #(.DATA_W(DATA_W)) u_dq (
    .clk(clk), .rst(rst), .latch_wr(latch_wr), .wdata(host_wdata),
    .drive_n(drive_n), .capture(capture), .dq_in(mem_dq_in),
    .dq_out(mem_dq_out), .dq_oe(mem_dq_oe), .rdata(host_rdata)
  );

  p_idle_deselect_r1: assert property (@(posedge clk) disable iff (rst)
    (mem_oe_n && mem_we_n && !mem_dq_oe) |-> (mem_sel_n != mem_sel) &&
    (mem_sel_n || mem_sel));

  p_read_no_drive_r2: assert property (@(posedge clk) disable iff (rst)
    !mem_oe_n |-> (!mem_sel_n && mem_sel && mem_we_n));

  p_we_selected_r5: assert property (@(posedge clk) disable iff (rst)
    !mem_we_n |-> (!mem_sel_n && mem_sel && mem_dq_oe));

  p_setup_r4: assert property (@(posedge clk) disable iff (rst)
    $fell(mem_we_n) |-> ($past(mem_dq_oe) && $stable(mem_addr)));

  p_hold_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_we_n) |-> (mem_dq_oe && !mem_sel_n && $stable(mem_addr)));

  p_no_contention_r7: assert property (@(posedge clk) disable iff (rst)
    !(mem_dq_oe && !mem_oe_n));

  p_turn_gap_r8: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_dq_oe) |-> $past(mem_oe_n));

  p_ack_pulse_r9: assert property (@(posedge clk) disable iff (rst)
    host_ack |=> !host_ack);

endmodule

// File: tb/tb_sram_ctl.sv
module tb_sram_ctl;

  localparam int AW    = 6;
  localparam int DW    = 8;
  localparam int TCLK  = 8000;
  localparam int DEPTH = 1 << AW;
  localparam int RD_EXP = (35000 + TCLK - 1) / TCLK;
  localparam int TA_EXP = (10000 + TCLK - 1) / TCLK;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req = 1'b0, wr = 1'b0;
  logic [AW-1:0] haddr = '0;
  logic [DW-1:0] hwdata = '0;
  logic ack;
  logic [DW-1:0] hrdata, dq_out, dq_in;
  logic [AW-1:0] maddr;
  logic sel_n, sel, oe_n, we_n, dq_oe;

  int n_tests = 0, n_fail = 0;
  int cycles = 0;

  always #4ns clk = ~clk;

  sram_ctl #(.ADDR_W(AW), .DATA_W(DW), .CLK_PS(TCLK), .FAST_GRADE(1)) dut (
    .clk(clk), .rst(rst), .host_req(req), .host_wr(wr), .host_addr(haddr),
    .host_wdata(hwdata), .host_ack(ack), .host_rdata(hrdata),
    .mem_addr(maddr), .mem_sel_n(sel_n), .mem_sel(sel), .mem_oe_n(oe_n),
    .mem_we_n(we_n), .mem_dq_out(dq_out), .mem_dq_in(dq_in), .mem_dq_oe(dq_oe)
  );

  // memory model with access-time check
  logic [DW-1:0] mem_m [DEPTH];
  logic [DW-1:0] exp_m [DEPTH];
  int rd_age = 0;
  logic we_prev = 1'b1;
  wire active = !sel_n && sel;

  assign dq_in = (active && !oe_n && we_n && rd_age >= RD_EXP - 1) ? mem_m[maddr] : 8'hA5;

  always @(posedge clk) begin
    rd_age  <= (active && !oe_n) ? rd_age + 1 : 0;
    we_prev <= we_n;
    if (!we_prev && we_n && active && dq_oe) mem_m[maddr] <= dq_out;
  end

  task automatic check(input bit ok, input string req_tag, input int act, input int expv);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req_tag, act, expv);
    end
  endtask

  // turnaround monitor: quiet clocks with oe_n high and no drive (R8)
  int quiet = 100;
  bit prev_oe_drv = 1'b0;
  bit after_read = 1'b0;
  always @(negedge clk) begin
    if (!rst) begin
      check(!(dq_oe && !oe_n), "R7", int'(dq_oe), 0);
      if (dq_oe && !prev_oe_drv && after_read) begin
        check(quiet >= TA_EXP + 1, "R8", quiet, TA_EXP + 1);
        after_read = 1'b0;
      end
      if (!oe_n) begin quiet = 0; after_read = 1'b1; end
      else if (!dq_oe) quiet++;
      prev_oe_drv = dq_oe;
    end
  end

  function automatic logic [DW-1:0] pat(input int a, input int k);
    return DW'((a * 29 + 7 + k * 83) & 8'hFF);
  endfunction

  task automatic access(input bit w, input int a, input logic [DW-1:0] d);
    int oe_lo = 0, we_lo = 0, pre = 0, post = 0, guard = 0;
    bit bad_addr = 0, bad_rd = 0, bad_sel = 0;
    @(negedge clk);
    req = 1'b1; wr = w; haddr = AW'(a); hwdata = d;
    forever begin
      @(negedge clk);
      guard++;
      if (ack) break;
      if (guard > 60) break;
      if (!oe_n) begin
        oe_lo++;
        if (maddr != AW'(a)) bad_addr = 1;
        if (!(active && we_n && !dq_oe)) bad_rd = 1;
      end
      if (dq_oe) begin
        if (maddr != AW'(a) || dq_out != d) bad_addr = 1;
        if (!active) bad_sel = 1;
        if (we_n && we_lo == 0) pre++;
        if (we_n && we_lo > 0) post++;
      end
      if (!we_n) begin
        we_lo++;
        if (!dq_oe) bad_sel = 1;
      end
    end
    req = 1'b0;
    check(ack, "R9", int'(ack), 1);
    if (w) begin
      exp_m[a] = d;
      check(!bad_addr, "R4", int'(bad_addr), 0);
      check(pre == 1, "R4", pre, 1);
      check(we_lo == RD_EXP && !bad_sel, "R5", we_lo, RD_EXP);
      check(post == 1, "R6", post, 1);
      check(oe_lo == 0, "R7", oe_lo, 0);
    end else begin
      check(!bad_addr && !bad_rd, "R2", int'(bad_addr) + int'(bad_rd), 0);
      check(oe_lo == RD_EXP, "R3", oe_lo, RD_EXP);
      check(hrdata == exp_m[a], "R3", int'(hrdata), int'(exp_m[a]));
    end
    @(negedge clk);
    check(!ack, "R9", int'(ack), 0);
    check(sel_n && !sel && oe_n && we_n && !dq_oe, "R1",
          {27'd0, sel_n, sel, oe_n, we_n, dq_oe}, 5'b10110);
    if (!w) check(hrdata == exp_m[a], "R3", int'(hrdata), int'(exp_m[a]));
  endtask

  task automatic finish_run();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
      finish_run();
    end
  end

  initial begin
    for (int i = 0; i < DEPTH; i++) begin mem_m[i] = 8'h00; exp_m[i] = 8'h00; end
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check(sel_n && !sel && oe_n && we_n && !dq_oe && !ack, "R1",
          {27'd0, sel_n, sel, oe_n, we_n, dq_oe}, 5'b10110);
    for (int a = 0; a < DEPTH; a++) access(1'b1, a, pat(a, 0));
    for (int a = 0; a < DEPTH; a++) access(1'b0, a, 8'h00);
    for (int a = DEPTH - 1; a >= 0; a--) begin
      access(1'b0, a, 8'h00);
      access(1'b1, a, pat(a, 1) ^ 8'hFF);
      access(1'b0, a, 8'h00);
    end
    for (int a = 0; a < DEPTH; a += 7) begin
      access(1'b1, a, 8'h00);
      access(1'b1, a, 8'hFF);
      access(1'b0, a, 8'h00);
    end
    finish_run();
  end

endmodule